// File: doc/BRIEF.md
# Weighted Vote Reveal Display Controller

This block collects ten single-bit judge votes and a reveal push-button operated by a scorekeeper who has no vote. A press of the button captures the votes and forms a weighted total. Judge 1 counts most, judges 2 and 3 count less, and the remaining seven judges count least. Judge 1 also holds a veto. When judge 1 does not agree at the moment of capture, no number is formed and the display shows a row of dashes instead.

The result drives an eight-digit, common-anode, seven-segment display. The digits are scanned one at a time. The display stays dark after reset until the first reveal. After a reveal it shows the total in decimal, right-aligned, with unused leading digits dark, or it shows eight dashes. The button is synchronized, debounced with a counter and edge-detected on chip, so one physical press gives exactly one capture. The vote switches are synchronized as well.

Top module: `vote_reveal_display`

## Requirements
- R1: On a reveal with judge 1 (`judge_agree[0]`) agreeing, the total is 10 for judge 1, plus 8 for each of `judge_agree[1]` and `judge_agree[2]` that is set, plus 5 for each set bit in `judge_agree[9:3]`. The largest possible total is 61.
- R2: On a reveal with `judge_agree[0]` low, every one of the eight digit positions shows the dash pattern `seg_n = 7'b0111111`, where only segment g is lit, whatever the other votes are.
- R3: After reset, and before the first reveal, every digit position shows `seg_n = 7'h7F` (all segments dark).
- R4: A number is right-aligned. Position 0 (`digit_en_n[0]` low) carries the units and position 1 carries the tens. The tens digit is dark when it would be a leading zero, and positions 2 to 7 are dark.
- R5: Segments are active low, with `seg_n[0]` = a through `seg_n[6]` = g. The digits 0 to 9 use the patterns 40,79,24,30,19,12,02,78,00,10 (hex).
- R6: Outside reset, exactly one bit of `digit_en_n` is low at a time. The low position steps 0,1,…,7,0 and moves on once every `SCAN_DIV` clock cycles.
- R7: Vote changes made after a reveal do not alter the display until the next reveal.
- R8: A button level that lasts fewer than `DEBOUNCE_CYCLES` cycles causes no reveal. Holding the button down gives only one reveal, so vote changes made while it is still held are not captured.
- R9: While `rst` is high, `digit_en_n` is all ones and `seg_n` is all ones. After reset the display is blank again until a new reveal.
- R10: Each new reveal replaces the shown result with one formed from the votes present at that press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| judge_agree | input | 10 | Vote switches, bit i = judge i+1, 1 = agree |
| reveal_btn | input | 1 | Raw scorekeeper reveal button, active high |
| digit_en_n | output | 8 | Active-low one-hot digit enable, bit 0 = rightmost |
| seg_n | output | 7 | Active-low segments, bit 0 = a … bit 6 = g |

## Verification
The bench builds the block with `DEBOUNCE_CYCLES = 4` and `SCAN_DIV = 2`. With these values a press settles within about ten cycles and a full scan of all eight digits takes 16 cycles. That makes it affordable to reveal every one of the 1024 vote patterns and compare a whole scanned frame against an arithmetic expectation. The same short constants also make the sub-threshold glitch, the held-button case and the scan stepping quick to exercise directly.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

    localparam int NUM_JUDGES = 10;
    localparam int NUM_DIGITS = 8;
    localparam int W_CHAIR    = 10;
    localparam int W_VICE     = 8;
    localparam int W_MEMBER   = 5;
    localparam int MAX_TOTAL  = W_CHAIR + 2 * W_VICE + (NUM_JUDGES - 3) * W_MEMBER;
    localparam int SUM_W      = $clog2(MAX_TOTAL + 1);
    localparam int DEC_DIGITS = 2;

    localparam logic [6:0] SEG_BLANK = 7'h7F;
    localparam logic [6:0] SEG_DASH  = 7'b0111111;

    typedef enum logic [1:0] {
        SHOW_BLANK = 2'd0,
        SHOW_NUM   = 2'd1,
        SHOW_DASH  = 2'd2
    } show_e;

    function automatic logic [SUM_W-1:0] weight_of(input int idx);
        if (idx == 0)     return SUM_W'(W_CHAIR);
        else if (idx < 3) return SUM_W'(W_VICE);
        else              return SUM_W'(W_MEMBER);
    endfunction

    // active-low, {g,f,e,d,c,b,a}
    function automatic logic [6:0] seg_of(input logic [3:0] dig);
        case (dig)
            4'd0:    return 7'h40;
            4'd1:    return 7'h79;
            4'd2:    return 7'h24;
            4'd3:    return 7'h30;
            4'd4:    return 7'h19;
            4'd5:    return 7'h12;
            4'd6:    return 7'h02;
            4'd7:    return 7'h78;
            4'd8:    return 7'h00;
            4'd9:    return 7'h10;
            default: return SEG_BLANK;
        endcase
    endfunction

endpackage

// File: rtl/vrd_button.sv
module vrd_button #(
    parameter int DEBOUNCE_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press_pulse
);
    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          level;
        logic [CW-1:0] cnt;
        logic          pulse;
    } btn_t;

    btn_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = btn_raw;
        st_d.s2    = st_q.s1;
        st_d.pulse = 1'b0;
        if (st_q.s2 != st_q.level) begin
            if (st_q.cnt == CW'(DEBOUNCE_CYCLES - 1)) begin
                st_d.level = st_q.s2;
                st_d.cnt   = '0;
                st_d.pulse = st_q.s2;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign press_pulse = st_q.pulse;

endmodule

// File: rtl/vrd_tally.sv
module vrd_tally
    import vrd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_JUDGES-1:0] votes_raw,
    input  logic                  capture,
    output show_e                 mode,
    output logic [SUM_W-1:0]      total
);
    typedef struct packed {
        logic [NUM_JUDGES-1:0] v1;
        logic [NUM_JUDGES-1:0] v2;
        show_e                 mode;
        logic [SUM_W-1:0]      total;
    } tally_t;

    tally_t           st_d, st_q;
    logic [SUM_W-1:0] sum_d;

    always_comb begin
        sum_d = '0;
        for (int i = 0; i < NUM_JUDGES; i++) begin
            if (st_q.v2[i]) sum_d = sum_d + weight_of(i);
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.v1 = votes_raw;
        st_d.v2 = st_q.v1;
        if (capture) begin
            if (st_q.v2[0]) begin
                st_d.mode  = SHOW_NUM;
                st_d.total = sum_d;
            end else begin
                st_d.mode  = SHOW_DASH;
                st_d.total = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.v1    <= '0;
            st_q.v2    <= '0;
            st_q.mode  <= SHOW_BLANK;
            st_q.total <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode  = st_q.mode;
    assign total = st_q.total;

endmodule

// File: rtl/vrd_bcd.sv
module vrd_bcd #(
    parameter int BIN_W  = 6,
    parameter int NDEC   = 2
) (
    input  logic [BIN_W-1:0]  bin,
    output logic [4*NDEC-1:0] bcd
);
    localparam int SW = BIN_W + 4 * NDEC;

    logic [SW-1:0] sh;

    always_comb begin
        sh = '0;
        sh[BIN_W-1:0] = bin;
        for (int b = 0; b < BIN_W; b++) begin
            for (int d = 0; d < NDEC; d++) begin
                if (sh[BIN_W + 4*d +: 4] >= 4'd5)
                    sh[BIN_W + 4*d +: 4] = sh[BIN_W + 4*d +: 4] + 4'd3;
            end
            sh = sh << 1;
        end
        bcd = sh[SW-1:BIN_W];
    end

endmodule

// File: rtl/vrd_scan.sv
module vrd_scan
    import vrd_pkg::*;
#(
    parameter int N_DIG    = 8,
    parameter int NDEC     = 2,
    parameter int SCAN_DIV = 6250
) (
    input  logic              clk,
    input  logic              rst,
    input  show_e             mode,
    input  logic [4*NDEC-1:0] bcd,
    output logic [N_DIG-1:0]  dig_n,
    output logic [6:0]        seg_n
);
    localparam int PW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam int IW = $clog2(N_DIG);

    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [IW-1:0]    idx;
        logic [N_DIG-1:0] dig_n;
        logic [6:0]       seg_n;
    } scan_t;

    scan_t       st_d, st_q;
    logic [6:0]  num_seg [N_DIG];

    // per-position numeric pattern, leading zeros dark
    genvar k;
    generate
        for (k = 0; k < N_DIG; k++) begin : g_pos
            if (k < NDEC) begin : g_dec
                logic upper_nz;
                always_comb begin
                    upper_nz = 1'b0;
                    for (int j = k; j < NDEC; j++)
                        if (bcd[4*j +: 4] != 4'd0) upper_nz = 1'b1;
                    if (k == 0 || upper_nz) num_seg[k] = seg_of(bcd[4*k +: 4]);
                    else                    num_seg[k] = SEG_BLANK;
                end
            end else begin : g_dark
                assign num_seg[k] = SEG_BLANK;
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (st_q.pre == PW'(SCAN_DIV - 1)) begin
            st_d.pre = '0;
            st_d.idx = (st_q.idx == IW'(N_DIG - 1)) ? '0 : st_q.idx + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
        st_d.dig_n = ~(N_DIG'(1) << st_q.idx);
        case (mode)
            SHOW_NUM:  st_d.seg_n = num_seg[st_q.idx];
            SHOW_DASH: st_d.seg_n = SEG_DASH;
            default:   st_d.seg_n = SEG_BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pre   <= '0;
            st_q.idx   <= '0;
            st_q.dig_n <= '1;
            st_q.seg_n <= SEG_BLANK;
        end else begin
            st_q <= st_d;
        end
    end

    assign dig_n = st_q.dig_n;
    assign seg_n = st_q.seg_n;

endmodule

// File: rtl/vote_reveal_display.sv
module vote_reveal_display
    import vrd_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 500000,
    parameter int SCAN_DIV        = 6250
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_JUDGES-1:0] judge_agree,
    input  logic                  reveal_btn,
    output logic [NUM_DIGITS-1:0] digit_en_n,
    output logic [6:0]            seg_n
);
    logic                  reveal_pulse;
    show_e                 show_mode;
    logic [SUM_W-1:0]      shown_total;
    logic [4*DEC_DIGITS-1:0] total_bcd;

    vrd_button #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_button (
        .clk        (clk),
        .rst        (rst),
        .btn_raw    (reveal_btn),
        .press_pulse(reveal_pulse)
    );

    vrd_tally u_tally (
        .clk      (clk),
        .rst      (rst),
        .votes_raw(judge_agree),
        .capture  (reveal_pulse),
        .mode     (show_mode),
        .total    (shown_total)
    );

    vrd_bcd #(.BIN_W(SUM_W), .NDEC(DEC_DIGITS)) u_bcd (
        .bin(shown_total),
        .bcd(total_bcd)
    );

    vrd_scan #(.N_DIG(NUM_DIGITS), .NDEC(DEC_DIGITS), .SCAN_DIV(SCAN_DIV)) u_scan (
        .clk  (clk),
        .rst  (rst),
        .mode (show_mode),
        .bcd  (total_bcd),
        .dig_n(digit_en_n),
        .seg_n(seg_n)
    );

endmodule

// File: rtl/vrd_checker.sv
module vrd_checker
    import vrd_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  pulse,
    input show_e                 mode,
    input logic [SUM_W-1:0]      total,
    input logic [NUM_DIGITS-1:0] dig_n,
    input logic [6:0]            seg_n
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_q | pulse;
    end

    assert_one_digit_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dig_n));

    assert_single_press_R8: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    assert_blank_before_reveal_R3: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> (seg_n == SEG_BLANK));

    assert_total_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        total <= SUM_W'(MAX_TOTAL));

    assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(pulse) |-> ($stable(mode) && $stable(total)));

    assert_dash_on_veto_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == SHOW_DASH) |-> (total == '0));

endmodule

bind vote_reveal_display vrd_checker u_vrd_checker (
    .clk  (clk),
    .rst  (rst),
    .pulse(reveal_pulse),
    .mode (show_mode),
    .total(shown_total),
    .dig_n(digit_en_n),
    .seg_n(seg_n)
);

// File: tb/tb_vote_reveal_display.sv
module tb_vote_reveal_display;

    localparam int DEB  = 4;
    localparam int DIV  = 2;
    localparam int NDIG = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] votes = '0;
    logic       btn = 1'b0;
    logic [7:0] dig_n;
    logic [6:0] seg_n;

    int errors = 0;
    int checks = 0;
    logic [6:0] frame [NDIG];
    logic [6:0] expf  [NDIG];
    logic [6:0] prevf [NDIG];

    always #2.5 clk = ~clk;

    vote_reveal_display #(.DEBOUNCE_CYCLES(DEB), .SCAN_DIV(DIV)) dut (
        .clk        (clk),
        .rst        (rst),
        .judge_agree(votes),
        .reveal_btn (btn),
        .digit_en_n (dig_n),
        .seg_n      (seg_n)
    );

    function automatic logic [6:0] code(input int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
            4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
            8: return 7'h00; default: return 7'h10;
        endcase
    endfunction

    function automatic int weighted(input logic [9:0] v);
        int t = 0;
        if (v[0]) t += 10;
        if (v[1]) t += 8;
        if (v[2]) t += 8;
        for (int i = 3; i < 10; i++) if (v[i]) t += 5;
        return t;
    endfunction

    task automatic build_expected(input logic [9:0] v);
        int t = weighted(v);
        for (int p = 0; p < NDIG; p++) expf[p] = 7'h7F;
        if (!v[0]) begin
            for (int p = 0; p < NDIG; p++) expf[p] = 7'b0111111;
        end else begin
            expf[0] = code(t % 10);
            if (t >= 10) expf[1] = code(t / 10);
        end
    endtask

    task automatic set_expected_blank();
        for (int p = 0; p < NDIG; p++) expf[p] = 7'h7F;
    endtask

    task automatic read_frame();
        for (int p = 0; p < NDIG; p++) frame[p] = 7'hxx;
        for (int c = 0; c < 2 * NDIG * DIV; c++) begin
            @(negedge clk);
            for (int p = 0; p < NDIG; p++)
                if (dig_n == ~(8'(1) << p)) frame[p] = seg_n;
        end
    endtask

    task automatic compare_frame(input string req, input int tag);
        checks++;
        for (int p = 0; p < NDIG; p++) begin
            if (frame[p] !== expf[p]) begin
                errors++;
                $display("FAIL %s case %0d pos %0d: actual=%h expected=%h",
                         req, tag, p, frame[p], expf[p]);
                return;
            end
        end
    endtask

    task automatic press(input int hold);
        btn = 1'b1;
        repeat (hold) @(negedge clk);
        btn = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int prevpos;
        int steps;
        logic okscan;
        repeat (4) @(negedge clk);
        // R9: reset holds everything dark
        checks++;
        if (dig_n !== 8'hFF || seg_n !== 7'h7F) begin
            errors++;
            $display("FAIL R9 in reset: actual=%h/%h expected=ff/7f", dig_n, seg_n);
        end
        rst = 1'b0;

        // R3: blank before any reveal
        votes = 10'h3FF;
        read_frame();
        set_expected_blank();
        compare_frame("R3", 0);

        // R6: scan order and one-cold enable
        okscan = 1'b1; prevpos = -1; steps = 0;
        for (int c = 0; c < 4 * NDIG * DIV; c++) begin
            int pos = -1;
            @(negedge clk);
            for (int p = 0; p < NDIG; p++) if (dig_n == ~(8'(1) << p)) pos = p;
            if (pos < 0) okscan = 1'b0;
            else if (prevpos >= 0 && pos != prevpos) begin
                if (pos != (prevpos + 1) % NDIG || steps != DIV) okscan = 1'b0;
                steps = 0;
            end
            if (pos >= 0 && prevpos >= 0 && pos == prevpos) steps++;
            if (prevpos < 0 || pos != prevpos) steps = 1;
            prevpos = pos;
        end
        checks++;
        if (!okscan) begin
            errors++;
            $display("FAIL R6 scan: actual=irregular expected=one-cold stepping every %0d", DIV);
        end

        // R1 R2 R4 R5 R10: every vote pattern
        for (int v = 0; v < 1024; v++) begin
            votes = 10'(v);
            repeat (3) @(negedge clk);
            press(12);
            read_frame();
            build_expected(10'(v));
            compare_frame(votes[0] ? "R1/R4/R5/R10" : "R2/R10", v);
        end

        // R7: votes changed after reveal have no effect
        votes = 10'b0000000111;
        repeat (3) @(negedge clk);
        press(12);
        read_frame();
        build_expected(10'b0000000111);
        compare_frame("R10", 2000);
        for (int p = 0; p < NDIG; p++) prevf[p] = expf[p];
        votes = 10'b0000000110;
        repeat (10) @(negedge clk);
        read_frame();
        compare_frame("R7", 2001);

        // R8: short glitch ignored
        votes = 10'h3FF;
        repeat (3) @(negedge clk);
        press(2);
        repeat (10) @(negedge clk);
        read_frame();
        compare_frame("R8 glitch", 2002);

        // R8: held button reveals once
        press_hold_check: begin
            btn = 1'b1;
            repeat (15) @(negedge clk);
            votes = 10'b0000000001;
            repeat (20) @(negedge clk);
            read_frame();
            build_expected(10'h3FF);
            compare_frame("R8 held", 2003);
            btn = 1'b0;
            repeat (10) @(negedge clk);
            read_frame();
            compare_frame("R8 release", 2004);
        end

        // R10: a following press takes the current votes
        press(12);
        read_frame();
        build_expected(10'b0000000001);
        compare_frame("R10", 2005);

        // R9: mid-run reset returns to blank
        rst = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (dig_n !== 8'hFF || seg_n !== 7'h7F) begin
            errors++;
            $display("FAIL R9 mid reset: actual=%h/%h expected=ff/7f", dig_n, seg_n);
        end
        rst = 1'b0;
        read_frame();
        set_expected_blank();
        compare_frame("R9 after", 2006);

        finish_run();
    end

endmodule